// File: doc/BRIEF.md
# Channel Interrupt Status Aggregator

This block gathers the interrupt state of a multi-channel DMA engine whose channels alternate in direction. Even-numbered channels move data from memory to a device, and odd-numbered channels move data from a device to memory. Each channel has a sticky status register and an enable mask. Both registers hold a descriptor-completion flag at bit 0 and a fault flag at bit 6.

Event pulses from the channel engines set status flags. Software clears a flag by writing a one to it. The enabled flags of every channel are reduced into a per-direction pending vector. Those two vectors, together with a small set of global flags, drive a single interrupt request line.

Software reaches all of the writable state through one write port. A two-bit target code selects what the write affects: 0 is channel status (clear by writing one), 1 is channel mask (load), and 2 is the global flags (clear by writing one). The current register contents are always visible on flat output buses.

Top module: `irq_status_agg`

## Requirements
- R1: After reset every channel status, every channel mask and every global flag is zero, both pending vectors are zero and `irq_o` is low.
- R2: A pulse on `evt_done[c]` sets bit 0 of channel c's status, and a pulse on `evt_err[c]` sets bit 6. The bit is visible one clock later and stays set until software clears it.
- R3: A write with target 0 clears each status bit of channel `wr_ch` that has a 1 in `wr_data`. Status bits that have a 0 in `wr_data` keep their value.
- R4: When an event and a clear of the same status bit fall in the same cycle, the bit ends up set.
- R5: A write with target 1 loads bits 0 and 6 of channel `wr_ch`'s mask from `wr_data`. The mask is otherwise unchanged.
- R6: Channel c is pending when its status AND mask is nonzero. An even channel c drives `tx_sum[c/2]`, and an odd channel c drives `rx_sum[(c-1)/2]`. The pending vectors follow the registers in the same cycle.
- R7: A fault flag whose mask bit 6 is 0 does not raise its pending bit or `irq_o`.
- R8: A pulse on `glb_evt[k]` sets global flag k one clock later. A write with target 2 clears the flags that have a 1 in `wr_data`, so an all-ones write clears every flag. A set in the same cycle as a clear wins.
- R9: `irq_o` is high exactly when some bit of `tx_sum`, `rx_sum` or `glb_flags` is set.
- R10: Status and mask bits other than 0 and 6 always read zero. A write aimed at one channel leaves every other channel's registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_done | input | NUM_CH | Descriptor-completion event pulse, one bit per channel |
| evt_err | input | NUM_CH | Fault event pulse, one bit per channel |
| glb_evt | input | GLB_W | Global flag set pulses |
| wr_en | input | 1 | Write strobe |
| wr_kind | input | 2 | Write target: 0 status clear, 1 mask load, 2 global clear |
| wr_ch | input | clog2(NUM_CH) | Channel addressed by the write |
| wr_data | input | REG_W | Write data |
| stat_flat | output | NUM_CH*REG_W | Channel status registers, channel c at bits [c*REG_W +: REG_W] |
| mask_flat | output | NUM_CH*REG_W | Channel mask registers, laid out the same way |
| glb_flags | output | GLB_W | Global flags |
| tx_sum | output | NUM_CH/2 | Pending vector of the even (transmit) channels |
| rx_sum | output | NUM_CH/2 | Pending vector of the odd (receive) channels |
| irq_o | output | 1 | Interrupt request |

## Verification
Every status, mask and global register is loaded on the clock edge after its event pulse or write. The pending vectors and `irq_o` are combinational from those registers, so all outputs settle during the same cycle, one edge after the stimulus.

The bench drives its inputs on the falling edge. Right after each rising edge it advances a behavioural model from the inputs it applied, and it compares every output with that model on the next falling edge. No result is ever sampled at the edge that produces it.

Directed sequences check set/clear collisions, mask-off of faults and the direction mapping at fixed points. A long randomized run then covers the remaining interleavings.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
   // write target selector carried on wr_kind
   typedef enum logic [1:0] {
      WK_STAT = 2'd0,
      WK_MASK = 2'd1,
      WK_GLB  = 2'd2,
      WK_NONE = 2'd3
   } wr_kind_e;
endpackage

// File: rtl/irq_agg_chan.sv
module irq_agg_chan #(
   parameter int REG_W    = 8,
   parameter int DONE_BIT = 0,
   parameter int ERR_BIT  = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             evt_done,
   input  logic             evt_err,
   input  logic             clr_we,
   input  logic             mask_we,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] stat_o,
   output logic [REG_W-1:0] mask_o,
   output logic             pend_o
);
   localparam logic [REG_W-1:0] DONE_M = REG_W'(1) << DONE_BIT;
   localparam logic [REG_W-1:0] ERR_M  = REG_W'(1) << ERR_BIT;
   localparam logic [REG_W-1:0] IMPL_M = DONE_M | ERR_M;

   logic [REG_W-1:0] stat_q, stat_d, mask_q, set_v;

   assign set_v = ({REG_W{evt_done}} & DONE_M) | ({REG_W{evt_err}} & ERR_M);

   always_comb begin
      stat_d = stat_q;
      if (clr_we) stat_d = stat_d & ~wr_data;
      stat_d = stat_d | set_v;   // set wins over clear
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         mask_q <= '0;
      end else begin
         stat_q <= stat_d & IMPL_M;
         if (mask_we) mask_q <= wr_data & IMPL_M;
      end
   end

   assign stat_o = stat_q;
   assign mask_o = mask_q;
   assign pend_o = |(stat_q & mask_q);

   // R2
   done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_done |=> stat_q[DONE_BIT]);

   // R4
   err_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_err && clr_we && wr_data[ERR_BIT]) |=> stat_q[ERR_BIT]);

   // R3
   done_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && wr_data[DONE_BIT] && !evt_done) |=> !stat_q[DONE_BIT]);

   // R10
   stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_we && !evt_done && !evt_err) |=> $stable(stat_q));

   // R5
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_we |=> $stable(mask_q));
endmodule

// File: rtl/irq_agg_glb.sv
module irq_agg_glb #(
   parameter int GLB_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [GLB_W-1:0] glb_evt,
   input  logic             clr_we,
   input  logic [GLB_W-1:0] wr_data,
   output logic [GLB_W-1:0] flags_o
);
   logic [GLB_W-1:0] flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= '0;
      else        flag_q <= (clr_we ? (flag_q & ~wr_data) : flag_q) | glb_evt;
   end

   assign flags_o = flag_q;

   // R8
   glb_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && (&wr_data) && !(|glb_evt)) |=> (flag_q == '0));

   // R8
   glb_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|glb_evt) |=> ((flag_q & $past(glb_evt)) == $past(glb_evt)));
endmodule

// File: rtl/irq_agg_sum.sv
module irq_agg_sum #(
   parameter int NUM_CH = 8
) (
   input  logic [NUM_CH-1:0]   pend,
   input  logic                glb_any,
   output logic [NUM_CH/2-1:0] tx_sum,
   output logic [NUM_CH/2-1:0] rx_sum,
   output logic                irq_o
);
   localparam int HALF = NUM_CH / 2;

   for (genvar k = 0; k < HALF; k++) begin : g_pair
      assign tx_sum[k] = pend[2*k];     // even channel: transmit
      assign rx_sum[k] = pend[2*k + 1]; // odd channel: receive
   end

   assign irq_o = (|tx_sum) | (|rx_sum) | glb_any;
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
   import irq_agg_pkg::*;
#(
   parameter int NUM_CH   = 8,
   parameter int REG_W    = 8,
   parameter int DONE_BIT = 0,
   parameter int ERR_BIT  = 6,
   parameter int GLB_W    = 4,
   localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int HALF    = NUM_CH / 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NUM_CH-1:0]       evt_done,
   input  logic [NUM_CH-1:0]       evt_err,
   input  logic [GLB_W-1:0]        glb_evt,
   input  logic                    wr_en,
   input  logic [1:0]              wr_kind,
   input  logic [CH_W-1:0]         wr_ch,
   input  logic [REG_W-1:0]        wr_data,
   output logic [NUM_CH*REG_W-1:0] stat_flat,
   output logic [NUM_CH*REG_W-1:0] mask_flat,
   output logic [GLB_W-1:0]        glb_flags,
   output logic [HALF-1:0]         tx_sum,
   output logic [HALF-1:0]         rx_sum,
   output logic                    irq_o
);
   if (NUM_CH < 2 || (NUM_CH % 2) != 0) begin : g_bad_ch
      $error("NUM_CH must be even and at least 2");
   end
   if (DONE_BIT == ERR_BIT || DONE_BIT >= REG_W || ERR_BIT >= REG_W) begin : g_bad_bits
      $error("flag bit positions must differ and fit in REG_W");
   end
   if (GLB_W < 1) begin : g_bad_glb
      $error("GLB_W must be at least 1");
   end

   wr_kind_e         kind;
   logic [NUM_CH-1:0] pend;
   logic             glb_clr;

   assign kind    = wr_kind_e'(wr_kind);
   assign glb_clr = wr_en && (kind == WK_GLB);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic hit;
      assign hit = wr_en && (wr_ch == CH_W'(c));

      irq_agg_chan #(
         .REG_W   (REG_W),
         .DONE_BIT(DONE_BIT),
         .ERR_BIT (ERR_BIT)
      ) chan_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .evt_done(evt_done[c]),
         .evt_err (evt_err[c]),
         .clr_we  (hit && (kind == WK_STAT)),
         .mask_we (hit && (kind == WK_MASK)),
         .wr_data (wr_data),
         .stat_o  (stat_flat[c*REG_W +: REG_W]),
         .mask_o  (mask_flat[c*REG_W +: REG_W]),
         .pend_o  (pend[c])
      );
   end

   irq_agg_glb #(.GLB_W(GLB_W)) glb_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .glb_evt(glb_evt),
      .clr_we (glb_clr),
      .wr_data(wr_data[GLB_W-1:0]),
      .flags_o(glb_flags)
   );

   irq_agg_sum #(.NUM_CH(NUM_CH)) sum_i (
      .pend   (pend),
      .glb_any(|glb_flags),
      .tx_sum (tx_sum),
      .rx_sum (rx_sum),
      .irq_o  (irq_o)
   );

   // R9
   irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(|stat_flat) && !(|glb_flags)) |-> !irq_o);

   // R7
   err_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(|(stat_flat & mask_flat)) && !(|glb_flags)) |-> (!irq_o && tx_sum == '0 && rx_sum == '0));
endmodule

// File: tb/irq_status_agg_tb_top.sv
`timescale 1ns/1ps
module irq_status_agg_tb_top;
   localparam int NCH = 8;
   localparam int RW  = 8;
   localparam int GW  = 4;
   localparam int HF  = NCH / 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NCH-1:0]  evt_done = '0;
   logic [NCH-1:0]  evt_err = '0;
   logic [GW-1:0]   glb_evt = '0;
   logic            wr_en = 1'b0;
   logic [1:0]      wr_kind = 2'd3;
   logic [2:0]      wr_ch = '0;
   logic [RW-1:0]   wr_data = '0;
   logic [NCH*RW-1:0] stat_flat, mask_flat;
   logic [GW-1:0]   glb_flags;
   logic [HF-1:0]   tx_sum, rx_sum;
   logic            irq_o;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   int m_stat[NCH];
   int m_mask[NCH];
   int m_glb;

   always #2.5 clk = ~clk;   // 200 MHz

   irq_status_agg #(.NUM_CH(NCH), .REG_W(RW), .GLB_W(GW)) dut_i (
      .clk(clk), .rst_n(rst_n), .evt_done(evt_done), .evt_err(evt_err),
      .glb_evt(glb_evt), .wr_en(wr_en), .wr_kind(wr_kind), .wr_ch(wr_ch),
      .wr_data(wr_data), .stat_flat(stat_flat), .mask_flat(mask_flat),
      .glb_flags(glb_flags), .tx_sum(tx_sum), .rx_sum(rx_sum), .irq_o(irq_o)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_step();
      if (!rst_n) begin
         for (int c = 0; c < NCH; c++) begin m_stat[c] = 0; m_mask[c] = 0; end
         m_glb = 0;
      end else begin
         for (int c = 0; c < NCH; c++) begin
            if (wr_en && wr_kind == 2'd0 && wr_ch == c) m_stat[c] = m_stat[c] & ~int'(wr_data);
            if (evt_done[c]) m_stat[c] = m_stat[c] | 'h01;
            if (evt_err[c])  m_stat[c] = m_stat[c] | 'h40;
            if (wr_en && wr_kind == 2'd1 && wr_ch == c) m_mask[c] = int'(wr_data) & 'h41;
         end
         if (wr_en && wr_kind == 2'd2) m_glb = m_glb & ~int'(wr_data[GW-1:0]);
         m_glb = (m_glb | int'(glb_evt)) & 'hF;
      end
   endtask

   task automatic compare_all();
      int etx, erx, eirq;
      etx = 0; erx = 0;
      for (int c = 0; c < NCH; c++) begin
         chk("R2 status", int'(stat_flat[c*RW +: RW]), m_stat[c]);
         chk("R5 mask", int'(mask_flat[c*RW +: RW]), m_mask[c]);
         if ((m_stat[c] & m_mask[c]) != 0) begin
            if (c % 2 == 0) etx = etx | (1 << (c / 2));
            else            erx = erx | (1 << ((c - 1) / 2));
         end
      end
      eirq = (etx != 0 || erx != 0 || m_glb != 0) ? 1 : 0;
      chk("R6 tx_sum", int'(tx_sum), etx);
      chk("R6 rx_sum", int'(rx_sum), erx);
      chk("R8 glb", int'(glb_flags), m_glb);
      chk("R9 irq", int'(irq_o), eirq);
   endtask

   task automatic tick();
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare_all();
   endtask

   task automatic idle();
      evt_done = '0; evt_err = '0; glb_evt = '0;
      wr_en = 1'b0; wr_kind = 2'd3; wr_data = '0;
   endtask

   task automatic wr(input int kind, input int ch, input int data);
      wr_en = 1'b1; wr_kind = 2'(kind); wr_ch = 3'(ch); wr_data = RW'(data);
   endtask

   initial begin
      #400000;
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      idle();
      for (int i = 0; i < 3; i++) tick();
      // R1: reset state
      chk("R1 stat", int'(|stat_flat), 0);
      chk("R1 mask", int'(|mask_flat), 0);
      chk("R1 glb", int'(glb_flags), 0);
      chk("R1 irq", int'(irq_o), 0);
      rst_n = 1'b1;
      tick();
      chk("R1 irq after release", int'(irq_o), 0);

      // R5 / R10: mask load keeps only bits 0 and 6
      wr(1, 2, 'hFF); tick(); idle();
      chk("R5 mask ch2", int'(mask_flat[2*RW +: RW]), 'h41);
      chk("R10 mask other ch", int'(mask_flat[3*RW +: RW]), 0);

      // R2 / R6 / R9
      evt_done[2] = 1'b1; tick(); idle();
      chk("R2 done set ch2", int'(stat_flat[2*RW +: RW]), 'h01);
      chk("R6 even ch2 -> tx bit1", int'(tx_sum), 'b0010);
      chk("R9 irq high", int'(irq_o), 1);
      tick();
      chk("R2 sticky", int'(stat_flat[2*RW +: RW]), 'h01);

      // R4: event with clear in same cycle
      evt_done[2] = 1'b1; wr(0, 2, 'h01); tick(); idle();
      chk("R4 set wins", int'(stat_flat[2*RW +: RW]), 'h01);

      // R3: zero bits leave status alone, one bits clear
      wr(0, 2, 'hFE); tick(); idle();
      chk("R3 zero bit keeps", int'(stat_flat[2*RW +: RW]), 'h01);
      wr(0, 3, 'hFF); tick(); idle();
      chk("R10 other ch write", int'(stat_flat[2*RW +: RW]), 'h01);
      wr(0, 2, 'h01); tick(); idle();
      chk("R3 cleared", int'(stat_flat[2*RW +: RW]), 0);
      chk("R3 irq low", int'(irq_o), 0);

      // R7: fault masked off
      wr(1, 5, 'h01); tick(); idle();
      evt_err[5] = 1'b1; tick(); idle();
      chk("R7 err status", int'(stat_flat[5*RW +: RW]), 'h40);
      chk("R7 rx masked", int'(rx_sum), 0);
      chk("R7 irq masked", int'(irq_o), 0);
      wr(1, 5, 'h40); tick(); idle();
      chk("R6 odd ch5 -> rx bit2", int'(rx_sum), 'b0100);
      chk("R9 irq err", int'(irq_o), 1);
      wr(0, 5, 'h40); tick(); idle();
      chk("R3 err cleared", int'(irq_o), 0);

      // R8: global flags
      glb_evt = 4'b1010; tick(); idle();
      chk("R8 glb set", int'(glb_flags), 'hA);
      chk("R9 irq glb", int'(irq_o), 1);
      glb_evt = 4'b0001; wr(2, 0, 'hFF); tick(); idle();
      chk("R8 set beats wipe", int'(glb_flags), 'h1);
      wr(2, 0, 'hFF); tick(); idle();
      chk("R8 wipe", int'(glb_flags), 0);
      chk("R9 irq drop", int'(irq_o), 0);

      // randomized interleaving
      for (int n = 0; n < 3000; n++) begin
         evt_done = NCH'($urandom & $urandom & $urandom);
         evt_err  = NCH'($urandom & $urandom & $urandom & $urandom);
         glb_evt  = GW'($urandom & $urandom & $urandom & $urandom);
         wr_en    = ($urandom % 3) == 0;
         wr_kind  = 2'($urandom);
         wr_ch    = 3'($urandom);
         wr_data  = RW'($urandom);
         tick();
      end
      idle();
      tick();

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule